// File: doc/BRIEF.md
# Static Memory Read Wait-State Controller

This block runs read cycles on an asynchronous external memory bus, all timed by the bus clock. A requester presents a 28-bit address, a chip-select index and a byte-lane mask. The controller then drives the address, one active-low chip select, an active-low output enable and active-low byte-lane enables. It holds them for a programmable number of whole clock periods. At the end of that window it captures the 32-bit read data, releases the strobes and reports the word with a one-cycle done pulse.

Every chip-select region has its own 3-bit wait-state setting, from 0 to 7, which a configuration write port loads. The setting is sampled when a request is taken, so slow and fast devices can share the bus. A ready output tells the requester when a new request will be taken. One idle clock separates the end of a read from the point where the next read can be accepted.

Top module: `smc_waitstate_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_done` is 0, every bit of `mem_cs_n` is 1, `mem_oe_n` is 1 and every bit of `mem_ble_n` is 1.
- R2: When `req_valid` is high while `req_ready` is high at a clock edge, the request is accepted. From that edge on, `mem_addr` equals `req_addr`. `mem_cs_n` has only bit `req_cs` low. `mem_oe_n` is low. `mem_ble_n` is the bitwise inverse of `req_lanes`, where bit k is the lane for `mem_rdata[8k+7:8k]`.
- R3: Chip select, output enable and lane enables stay asserted for exactly W+1 clock cycles, where W is the wait-state setting of the selected region. Read data is captured at the edge that ends the last of these cycles.
- R4: At the capture edge, all strobes return high together. In the cycle that follows, `rd_done` is high for exactly one cycle, with `rd_data` equal to the `mem_rdata` value present just before the capture edge.
- R5: `mem_addr` stays unchanged from acceptance through the capture edge, and keeps its value until the next request is accepted.
- R6: `req_ready` is low from acceptance until one full idle cycle after the capture edge. It is still low in the cycle where `rd_done` is high and returns high in the next cycle. A request presented while `req_ready` is low is ignored and produces no access.
- R7: A pulse on `cfg_we` writes `cfg_ws` into the wait-state setting of region `cfg_sel`. The value used by an access is the setting present when the request is accepted. A write made during an access does not affect that access.
- R8: After reset, every region's wait-state setting is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a wait-state setting |
| cfg_sel | input | 3 | Region whose setting is written |
| cfg_ws | input | 3 | New wait-state count (0 to 7) |
| req_valid | input | 1 | Read request present |
| req_addr | input | 28 | Read address |
| req_cs | input | 3 | Chip-select region index |
| req_lanes | input | 4 | Byte lanes wanted, active high |
| req_ready | output | 1 | Controller can accept a request |
| rd_data | output | 32 | Captured read word |
| rd_done | output | 1 | One-cycle pulse: `rd_data` is valid |
| mem_addr | output | 28 | External address bus |
| mem_cs_n | output | 8 | Active-low chip selects, one per region |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ble_n | output | 4 | Active-low byte-lane enables |
| mem_rdata | input | 32 | External read data bus |

## Verification
The bench uses the default parameters: eight regions, a 3-bit wait field and a 28/32-bit bus. This covers every wait-state code from 0 to 7, on every chip-select output, including the reset default of 7. The bench's memory model returns a word that changes on every active clock. A capture one edge too early or too late therefore shows up as a wrong data value, and the strobe window length is also measured directly. Because the wait field is narrow, reprogramming during an access and requests made while busy can be checked on a single region in a few dozen cycles.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ACTIVE  = 2'd1,
    SEQ_RECOVER = 2'd2
  } seq_state_e;

  localparam int unsigned DEF_ADDR_W = 28;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_NUM_CS = 8;
  localparam int unsigned DEF_WS_W   = 3;
endpackage

// File: rtl/smc_ws_bank.sv
module smc_ws_bank #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned WS_W   = 3,
  localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CS_W-1:0] wr_sel,
  input  logic [WS_W-1:0] wr_val,
  input  logic [CS_W-1:0] rd_sel,
  output logic [WS_W-1:0] rd_val
);
  localparam logic [WS_W-1:0] WS_RESET = '1;

  logic [WS_W-1:0] ws_q [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_region
    logic hit;
    assign hit = wr_en && (wr_sel == CS_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ws_q[g] <= WS_RESET;
      else if (hit) ws_q[g] <= wr_val;
    end
  end

  assign rd_val = ws_q[rd_sel];
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int unsigned WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [WS_W-1:0] ws_in,
  output logic            ready,
  output logic            accept,
  output logic            latch,
  output logic [WS_W-1:0] act_cnt,
  output logic [WS_W-1:0] ws_snap
);
  seq_state_e      state_q;
  logic [WS_W-1:0] left_q;

  function automatic logic [WS_W-1:0] count_down(input logic [WS_W-1:0] v);
    return v - WS_W'(1);
  endfunction

  function automatic logic [WS_W-1:0] count_up(input logic [WS_W-1:0] v);
    return v + WS_W'(1);
  endfunction

  assign ready  = (state_q == SEQ_IDLE);
  assign accept = ready && req_valid;
  assign latch  = (state_q == SEQ_ACTIVE) && (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      left_q  <= '0;
      act_cnt <= '0;
      ws_snap <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (accept) begin
          state_q <= SEQ_ACTIVE;
          left_q  <= ws_in;
          ws_snap <= ws_in;
          act_cnt <= '0;
        end
        SEQ_ACTIVE: if (latch) begin
          state_q <= SEQ_RECOVER;
        end else begin
          left_q  <= count_down(left_q);
          act_cnt <= count_up(act_cnt);
        end
        SEQ_RECOVER: state_q <= SEQ_IDLE;
        default:     state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R3: the capture point is reached after exactly the snapshotted wait count
  assert_wait_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (act_cnt == ws_snap));

  // R6: no new access is taken on the cycle after capture
  assert_recover_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !ready);
endmodule

// File: rtl/smc_pins.sv
module smc_pins #(
  parameter int unsigned ADDR_W = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              latch,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [LANES-1:0]  req_lanes,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_ble_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done
);
  logic [NUM_CS-1:0] cs_sel_n;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_dec
    assign cs_sel_n[g] = (req_cs != CS_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_cs_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_ble_n <= '1;
    end else if (accept) begin
      mem_addr  <= req_addr;
      mem_cs_n  <= cs_sel_n;
      mem_oe_n  <= 1'b0;
      mem_ble_n <= ~req_lanes;
    end else if (latch) begin
      mem_cs_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_ble_n <= '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= latch;
      if (latch) rd_data <= mem_rdata;
    end
  end

  // R2: at most one chip select is ever driven low
  assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  // R2: output enable tracks the presence of a selected region
  assert_oe_with_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe_n == (&mem_cs_n)));

  // R5: address is stable while the strobes stay asserted
  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  // R4: done follows the release of the strobes and lasts one cycle
  assert_done_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (mem_oe_n && $past(!mem_oe_n)));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
endmodule

// File: rtl/smc_waitstate_ctrl.sv
module smc_waitstate_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NUM_CS = DEF_NUM_CS,
  parameter int unsigned WS_W   = DEF_WS_W,
  localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CS_W-1:0]   cfg_sel,
  input  logic [WS_W-1:0]   cfg_ws,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [LANES-1:0]  req_lanes,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_ble_n,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [WS_W-1:0] sel_ws;
  logic            accept_w;
  logic            latch_w;
  logic [WS_W-1:0] act_cnt_w;
  logic [WS_W-1:0] ws_snap_w;

  smc_ws_bank #(.NUM_CS(NUM_CS), .WS_W(WS_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_sel (cfg_sel),
    .wr_val (cfg_ws),
    .rd_sel (req_cs),
    .rd_val (sel_ws)
  );

  smc_seq #(.WS_W(WS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ws_in     (sel_ws),
    .ready     (req_ready),
    .accept    (accept_w),
    .latch     (latch_w),
    .act_cnt   (act_cnt_w),
    .ws_snap   (ws_snap_w)
  );

  smc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .latch     (latch_w),
    .req_addr  (req_addr),
    .req_cs    (req_cs),
    .req_lanes (req_lanes),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_ble_n (mem_ble_n),
    .rd_data   (rd_data),
    .rd_done   (rd_done)
  );

  // R6: the done cycle is still part of the busy window
  assert_busy_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !req_ready);

  // R6: strobes are never asserted while the controller reports ready
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_oe_n);
endmodule

// File: tb/smc_waitstate_ctrl_test.sv
module smc_waitstate_ctrl_test;
  localparam int AW = 28;
  localparam int DW = 32;
  localparam int NCS = 8;

  typedef struct {
    logic [AW-1:0] addr;
    logic [2:0]    cs;
    logic [3:0]    lanes;
    int            ws;
    logic [DW-1:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [2:0] cfg_ws = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] req_cs = '0;
  logic [3:0] req_lanes = '0;
  logic req_ready;
  logic [DW-1:0] rd_data;
  logic rd_done;
  logic [AW-1:0] mem_addr;
  logic [NCS-1:0] mem_cs_n;
  logic mem_oe_n;
  logic [3:0] mem_ble_n;
  logic [DW-1:0] mem_rdata;

  int n_checks = 0;
  int n_fail = 0;
  int n_pushed = 0;
  int n_done = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  smc_waitstate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_ws(cfg_ws),
    .req_valid(req_valid), .req_addr(req_addr), .req_cs(req_cs), .req_lanes(req_lanes),
    .req_ready(req_ready), .rd_data(rd_data), .rd_done(rd_done), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_ble_n(mem_ble_n), .mem_rdata(mem_rdata)
  );

  // memory model: word depends on address, region and cycles since enable
  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a, input int cs);
    return {4'(cs) ^ 4'h5, a} ^ 32'h0F0F_0000;
  endfunction

  function automatic int low_index(input logic [NCS-1:0] v);
    for (int i = 0; i < NCS; i++) if (!v[i]) return i;
    return 0;
  endfunction

  int on_cycles;
  always @(posedge clk) begin
    if (!rst_n || mem_oe_n) on_cycles <= 0;
    else on_cycles <= on_cycles + 1;
  end
  assign mem_rdata = pattern(mem_addr, low_index(mem_cs_n)) + 32'(on_cycles);

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic program_ws(input int cs, input int ws);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(cs); cfg_ws = 3'(ws);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int cs, input logic [3:0] ln,
                         input int ws);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    it.addr = a; it.cs = 3'(cs); it.lanes = ln; it.ws = ws;
    it.data = pattern(a, cs) + 32'(ws);
    sb.push_back(it);
    n_pushed++;
    req_valid = 1'b1; req_addr = a; req_cs = 3'(cs); req_lanes = ln;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  int act_len = 0;
  bit prev_on = 1'b0;
  bit ready_next = 1'b0;
  logic [AW-1:0] addr_seen;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ready_next) begin
        check(req_ready == 1'b1, "R6 ready after idle cycle", 32'(req_ready), 32'd1);
        ready_next = 1'b0;
      end
      if (!mem_oe_n) begin
        if (!prev_on) begin
          act_len = 1;
          addr_seen = mem_addr;
          if (sb.size() == 0) begin
            check(1'b0, "R6 access without request", 32'(mem_addr), 32'd0);
          end else begin
            check(mem_addr == sb[0].addr, "R2 address", 32'(mem_addr), 32'(sb[0].addr));
            check(mem_cs_n == ~(8'd1 << sb[0].cs), "R2 chip select",
                  32'(mem_cs_n), 32'(~(8'd1 << sb[0].cs)));
            check(mem_ble_n == ~sb[0].lanes, "R2 lane enables",
                  32'(mem_ble_n), 32'(~sb[0].lanes));
          end
        end else begin
          act_len++;
          check(mem_addr == addr_seen, "R5 address stable", 32'(mem_addr), 32'(addr_seen));
        end
      end
      prev_on = !mem_oe_n;
      if (rd_done) begin
        n_done++;
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected done", rd_data, 32'd0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(rd_data == it.data, "R4 captured data", rd_data, it.data);
          check(act_len == it.ws + 1, "R3 strobe window", 32'(act_len), 32'(it.ws + 1));
          check(mem_cs_n == '1 && mem_oe_n && mem_ble_n == '1, "R4 strobes released",
                {23'd0, mem_cs_n, mem_oe_n}, {23'd0, 8'hFF, 1'b1});
          check(mem_addr == it.addr, "R5 address held", 32'(mem_addr), 32'(it.addr));
          check(req_ready == 1'b0, "R6 busy during done", 32'(req_ready), 32'd0);
          ready_next = 1'b1;
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    check(rd_done == 1'b0, "R1 done", 32'(rd_done), 32'd0);
    check(mem_cs_n == '1, "R1 cs", 32'(mem_cs_n), 32'hFF);
    check(mem_oe_n == 1'b1, "R1 oe", 32'(mem_oe_n), 32'd1);
    check(mem_ble_n == '1, "R1 lanes", 32'(mem_ble_n), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after release", 32'(req_ready), 32'd1);

    // R8: default setting of 7 on unprogrammed regions
    do_read(28'h0ABCDE0, 0, 4'hF, 7);
    do_read(28'hFFFFFFF, 7, 4'h1, 7);

    // R7: program every region with a distinct count, then read each
    for (int i = 0; i < NCS; i++) program_ws(i, (i * 3) % 8);
    for (int i = 0; i < NCS; i++)
      do_read(28'(32'h0123457 * (i + 1)), i, 4'(i + 1), (i * 3) % 8);
    // back-to-back reads on the zero-wait region (cs0) with other lane masks
    do_read(28'h0000000, 0, 4'h0, 0);
    do_read(28'h5555555, 0, 4'hA, 0);
    do_read(28'hAAAAAAA, 5, 4'h5, 7);

    // R6: requests while busy are ignored
    do_read(28'h1111110, 2, 4'hC, 6);
    req_valid = 1'b1; req_addr = 28'h7777777; req_cs = 3'd4; req_lanes = 4'h3;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(mem_oe_n == 1'b1, "R6 busy request ignored", 32'(mem_oe_n), 32'd1);

    // R7: a write during an access does not alter that access
    program_ws(3, 5);
    do_read(28'h0C0FFEE, 3, 4'h6, 5);
    program_ws(3, 1);
    repeat (2) @(negedge clk);
    do_read(28'h0BEEF00, 3, 4'h9, 1);

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(n_done == n_pushed, "R6 completion count", 32'(n_done), 32'(n_pushed));
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule